// File: doc/BRIEF.md
# Laser Transmitter Fault Supervisor

This block supervises the current enables of an optical transmitter. External comparators turn the analog monitor nodes into single-bit fault flags. The block synchronises these flags and qualifies them. It latches the first qualified fault into an active-high FAIL output and records which flags caused it. Two conditions force the bias and modulation enables low: a transmit-disable request, or a latched fault while the shutdown policy is active.

After reset, all alarms are blanked for an initialisation window. There is only one way to clear a latched fault. The disable input must be held high for at least a minimum width and then released. The release clears FAIL and the cause register and starts the initialisation window again. Power-on and fault recovery therefore follow the same path.

All timing windows are counters derived from a clock-frequency parameter given in MHz. The default windows are 25 ms for initialisation and 5 us for the clear pulse. Every asynchronous input passes through a two-flop synchroniser. The disable input's synchroniser resets to the asserted state, so an undriven or not-yet-sampled disable keeps the currents off.

Top module: `ltx_fault_supervisor`

## Requirements
- R1: During reset, and for the first two clock edges after reset is released, both enables, `fail_o`, `init_done_o` and `fault_cause_o` are 0, whatever level the disable pin has.
- R2: `init_done_o` rises exactly INIT_US*CLK_MHZ clock edges after reset release. A fault flag that is present only before that point never sets `fail_o`.
- R3: Once armed, a fault flag at the pin sets `fail_o` on the third clock edge after the flag is sampled. On the same edge, `fault_cause_o` captures the qualified flags. The bit positions are: 0 bias monitor over threshold, 1 power-set node over its high limit, 2 power-set node under its low limit, 3 laser cathode shorted to ground, 4 extinction-reference node shorted to supply.
- R4: `fail_o` and `fault_cause_o` hold their values after the causing flag goes away.
- R5: A high level on the disable pin drives both enables to 0 on the third clock edge. A low level with no shutdown fault returns them to 1 on the third edge.
- R6: A latched fault is cleared on the third edge after the disable pin falls, but only if the pin was high for at least CLR_US*CLK_MHZ clock edges. A shorter pulse leaves `fail_o` and `fault_cause_o` unchanged.
- R7: A clear drops `init_done_o` on the same edge. Faults are then ignored for a full initialisation window before the block re-arms. A disable pulse with no fault latched does not restart initialisation.
- R8: When `rset_mode_i` is 1 (resistor setpoint), flag bit 4 is ignored. When it is 0 (voltage setpoint), flag bit 4 is honoured.
- R9: With `fail_o` set, the enables are 0 if `shut_on_fault_i` is 1 and stay 1 if it is 0. `bias_en_o` always equals `mod_en_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_disable_i | input | 1 | Transmit disable request, asynchronous, active high |
| rset_mode_i | input | 1 | 1 = resistor setpoint mode, 0 = voltage setpoint mode |
| shut_on_fault_i | input | 1 | 1 = force currents off while FAIL is latched |
| fault_flags_i | input | 5 | Digitised fault flags from the monitor comparators |
| bias_en_o | output | 1 | Bias current enable |
| mod_en_o | output | 1 | Modulation current enable |
| fail_o | output | 1 | Latched fault alarm, active high |
| init_done_o | output | 1 | Initialisation window finished, alarms armed |
| fault_cause_o | output | 5 | Qualified flags captured when FAIL was set |

## Verification
The hardest state to reach from the ports is the clear path. It needs a fault latched after the blanking window, then a disable pulse whose width lands exactly around the minimum. It then needs a new flag applied while the restarted window is still running. The bench builds this with short windows: a 1 MHz parameter value and 40-cycle and 5-cycle windows. It sweeps pulse widths from one cycle to beyond the limit. After every clear it immediately re-applies a flag, shows that the flag stays blanked until the new window ends, and then shows that the fault latches again. That fault feeds the next width in the sweep.

// File: rtl/ltx_pkg.sv
package ltx_pkg;
  localparam int NFLT = 5;

  // Flag bit positions (fixed: external comparators wire to these)
  localparam int FI_BIAS_HI  = 0;
  localparam int FI_PSET_HI  = 1;
  localparam int FI_PSET_LO  = 2;
  localparam int FI_CATH_GND = 3;
  localparam int FI_EREF_VCC = 4;

  typedef logic [NFLT-1:0] fvec_t;

  // In resistor setpoint mode the extinction reference is strapped high.
  function automatic fvec_t qual_mask(input logic rset_mode);
    fvec_t m;
    m = '1;
    if (rset_mode) m[FI_EREF_VCC] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/ltx_sync.sv
module ltx_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= RST_VAL[i];
        q[i]    <= RST_VAL[i];
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/ltx_init_timer.sv
module ltx_init_timer #(
  parameter int INIT_CYC = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(INIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= '0;
    else if (cnt != LAST)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/ltx_clear_detect.sv
module ltx_clear_detect #(
  parameter int CLR_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_s,
  output logic clr_ok
);
  localparam int CW = $clog2(CLR_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(CLR_CYC);

  logic [CW-1:0] hi_cnt;
  logic          dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      dis_q  <= 1'b1;
    end else begin
      dis_q <= dis_s;
      if (!dis_s)            hi_cnt <= '0;
      else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // falling edge of the synchronised request after a long enough high
  assign clr_ok = dis_q & ~dis_s & (hi_cnt == SAT);
endmodule

// File: rtl/ltx_fault_latch.sv
module ltx_fault_latch
  import ltx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  armed,
  input  fvec_t qual,
  input  logic  clear,
  output logic  fail,
  output fvec_t cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail  <= 1'b0;
      cause <= '0;
    end else if (clear) begin
      fail  <= 1'b0;
      cause <= '0;
    end else if (armed && !fail && (|qual)) begin
      fail  <= 1'b1;
      cause <= qual;
    end
  end
endmodule

// File: rtl/ltx_fault_supervisor.sv
module ltx_fault_supervisor
  import ltx_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int INIT_US = 25000,
  parameter int CLR_US  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_disable_i,
  input  logic            rset_mode_i,
  input  logic            shut_on_fault_i,
  input  logic [NFLT-1:0] fault_flags_i,
  output logic            bias_en_o,
  output logic            mod_en_o,
  output logic            fail_o,
  output logic            init_done_o,
  output logic [NFLT-1:0] fault_cause_o
);
  localparam int INIT_CYC = CLK_MHZ * INIT_US;
  localparam int CLR_CYC  = CLK_MHZ * CLR_US;
  localparam int SW       = NFLT + 3;
  // disable resets asserted, everything else deasserted
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] raw_in, sync_out;
  logic          dis_s, mode_s, pol_s;
  fvec_t         flg_s, qual;
  logic          clr_ok, clr_req, init_done, fail;
  fvec_t         cause;
  logic          en_q;

  assign raw_in = {tx_disable_i, rset_mode_i, shut_on_fault_i, fault_flags_i};

  ltx_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign {dis_s, mode_s, pol_s, flg_s} = sync_out;
  assign qual = flg_s & qual_mask(mode_s);

  ltx_clear_detect #(.CLR_CYC(CLR_CYC)) u_clr (
    .clk    (clk),
    .rst_n  (rst_n),
    .dis_s  (dis_s),
    .clr_ok (clr_ok)
  );

  assign clr_req = clr_ok & fail;

  ltx_init_timer #(.INIT_CYC(INIT_CYC)) u_init (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (clr_req),
    .done    (init_done)
  );

  ltx_fault_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (init_done),
    .qual  (qual),
    .clear (clr_req),
    .fail  (fail),
    .cause (cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ~dis_s & ~(fail & pol_s);
  end

  assign bias_en_o     = en_q;
  assign mod_en_o      = en_q;
  assign fail_o        = fail;
  assign init_done_o   = init_done;
  assign fault_cause_o = cause;
endmodule

// File: rtl/ltx_fault_supervisor_chk.sv
module ltx_fault_supervisor_chk
  import ltx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tx_disable_i,
  input logic            rset_mode_i,
  input logic            shut_on_fault_i,
  input logic [NFLT-1:0] fault_flags_i,
  input logic            bias_en_o,
  input logic            mod_en_o,
  input logic            fail_o,
  input logic            init_done_o,
  input logic [NFLT-1:0] fault_cause_o
);
  // R2: the alarm only rises once the window had completed
  assert_arm_after_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> $past(init_done_o));

  // R3: a set alarm always names a cause, a clear one names none
  assert_cause_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o == (fault_cause_o != '0));

  // R5: disable seen three edges back keeps the currents off
  assert_disable_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_disable_i, 3) |-> (!bias_en_o && !mod_en_o));

  // R7: clearing the alarm restarts initialisation
  assert_clear_reinit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_o) |-> !init_done_o);

  // R8: resistor mode never records the reference-short flag
  assert_eref_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fail_o) && $past(rset_mode_i, 3)) |-> !fault_cause_o[FI_EREF_VCC]);

  // R9: shutdown policy forces currents off under a latched alarm
  assert_policy_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fail_o) && $past(shut_on_fault_i, 3)) |-> !bias_en_o);

  // R9: the two enables never differ
  assert_enables_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bias_en_o == mod_en_o);
endmodule

bind ltx_fault_supervisor ltx_fault_supervisor_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_disable_i    (tx_disable_i),
  .rset_mode_i     (rset_mode_i),
  .shut_on_fault_i (shut_on_fault_i),
  .fault_flags_i   (fault_flags_i),
  .bias_en_o       (bias_en_o),
  .mod_en_o        (mod_en_o),
  .fail_o          (fail_o),
  .init_done_o     (init_done_o),
  .fault_cause_o   (fault_cause_o)
);

// File: tb/sim_ltx_fault_supervisor.sv
module sim_ltx_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ  = 1;
  localparam int IUS  = 40;
  localparam int CUS  = 5;
  localparam int INIT = MHZ * IUS;
  localparam int CLR  = MHZ * CUS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_disable = 1'b0;
  logic       rset_mode = 1'b0;
  logic       shut = 1'b1;
  logic [4:0] flags = '0;
  logic       bias_en, mod_en, fail, init_done;
  logic [4:0] cause;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ltx_fault_supervisor #(.CLK_MHZ(MHZ), .INIT_US(IUS), .CLR_US(CUS)) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .tx_disable_i    (tx_disable),
    .rset_mode_i     (rset_mode),
    .shut_on_fault_i (shut),
    .fault_flags_i   (flags),
    .bias_en_o       (bias_en),
    .mod_en_o        (mod_en),
    .fail_o          (fail),
    .init_done_o     (init_done),
    .fault_cause_o   (cause)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      summary();
    end
  end

  initial begin
    // R1: reset state, disable pin low but internally treated as asserted
    tick(3);
    chk(!bias_en && !mod_en && !fail && !init_done && cause == 0, "R1 in reset",
        {bias_en, mod_en, fail, init_done}, 0);
    rst_n = 1'b1;
    tick(2);
    chk(!bias_en && !mod_en, "R1 enables off 2 edges after reset", bias_en, 0);
    chk(!fail && !init_done && cause == 0, "R1 status after reset", fail, 0);
    tick(1);
    chk(bias_en && mod_en, "R5 enables on 3rd edge", bias_en, 1);

    // R2: flag inside the window is ignored; window length is exact
    flags = 5'b00001;
    tick(INIT - 13);
    flags = '0;
    tick(9);
    chk(!init_done, "R2 init_done low at INIT-1", init_done, 0);
    chk(!fail, "R2 no fail during window", fail, 0);
    tick(1);
    chk(init_done, "R2 init_done high at INIT", init_done, 1);
    tick(5);
    chk(!fail, "R2 early flag ignored", fail, 0);

    // R5: disable timing with no fault; no init restart (R7)
    tx_disable = 1'b1;
    tick(2);
    chk(bias_en, "R5 enables still on after 2 edges", bias_en, 1);
    tick(1);
    chk(!bias_en && !mod_en, "R5 enables off on 3rd edge", bias_en, 0);
    tick(10);
    tx_disable = 1'b0;
    tick(2);
    chk(!bias_en, "R5 enables still off after 2 edges", bias_en, 0);
    tick(1);
    chk(bias_en && mod_en, "R5 enables back on 3rd edge", bias_en, 1);
    chk(init_done, "R7 no reinit without fault", init_done, 1);

    // R3/R4/R8/R9 sweep over mode and each flag bit
    for (int m = 0; m < 2; m++) begin
      rset_mode = m[0];
      tick(4);
      for (int b = 0; b < 5; b++) begin
        bit exp;
        exp = !(b == 4 && m == 1);
        flags = 5'(1 << b);
        tick(2);
        chk(!fail, "R3 no fail after 2 edges", fail, 0);
        tick(1);
        chk(fail == exp, (b == 4) ? "R8 ref-short flag by mode" : "R3 fail on 3rd edge", fail, exp);
        chk(cause == (exp ? 5'(1 << b) : 5'd0), "R3 cause bit position", cause, exp ? (1 << b) : 0);
        tick(1);
        chk(bias_en == !exp, "R9 shutdown policy enables", bias_en, !exp);
        flags = '0;
        tick(4);
        chk(fail == exp, "R4 fail held after flag removed", fail, exp);
        chk(cause == (exp ? 5'(1 << b) : 5'd0), "R4 cause held", cause, exp ? (1 << b) : 0);
        if (exp) begin
          tx_disable = 1'b1;
          tick(CLR);
          tx_disable = 1'b0;
          tick(3);
          chk(!fail && cause == 0, "R6 clear with full pulse", fail, 0);
          tick(INIT + 2);
          chk(init_done, "R7 re-armed after window", init_done, 1);
        end
      end
    end
    rset_mode = 1'b0;
    tick(4);

    // R9: inhibit policy keeps currents on while FAIL is set
    shut = 1'b0;
    tick(4);
    flags = 5'b00010;
    tick(6);
    chk(fail, "R9 fail with policy inhibited", fail, 1);
    chk(bias_en && mod_en, "R9 currents stay on", bias_en, 1);
    flags = '0;
    shut = 1'b1;
    tick(3);
    chk(!bias_en && !mod_en, "R9 currents off once policy active", bias_en, 0);

    // R6/R7: sweep disable pulse width around the minimum
    for (int w = 1; w <= CLR + 2; w++) begin
      bit clr;
      clr = (w >= CLR);
      tx_disable = 1'b1;
      tick(w);
      tx_disable = 1'b0;
      tick(2);
      chk(fail, "R6 fail unchanged 2 edges after fall", fail, 1);
      tick(1);
      chk(fail == !clr, "R6 clear depends on pulse width", fail, !clr);
      chk(cause == (clr ? 5'd0 : 5'b00010) || cause == (clr ? 5'd0 : 5'b00100),
          "R6 cause follows fail", cause, clr ? 0 : 2);
      if (clr) begin
        chk(!init_done, "R7 init restarted by clear", init_done, 0);
        flags = 5'b00100;
        tick(INIT - 1);
        chk(!fail && !init_done, "R7 flag blanked during new window", fail, 0);
        tick(5);
        chk(fail && cause == 5'b00100, "R7 fault latches after new window", cause, 4);
        flags = '0;
        tick(4);
      end
    end

    finished = 1'b1;
    summary();
  end
endmodule